// File: doc/BRIEF.md
# DMA Channel Termination Controller

This block is the completion and termination logic of one DMA channel that moves data between memory and an on-chip peripheral using dual-address (read then write) transfers. It takes descriptors carrying a beat count, issues one read/write pair per beat to a bus engine, and pulses an acknowledge strobe while the final pair of each descriptor is in flight. It updates sticky status flags and the channel-active bit as descriptors and chains finish.

An active-low done line can end a transfer early. A done edge that arrives while the acknowledge is high ends either the current descriptor or the whole chain, depending on a control bit. A done edge outside the acknowledge window is flagged as a protocol error. The line can also be driven by the block itself through an open-drain output enable.

Descriptors arrive on a valid/ready stream. The block asserts `desc_ready` only when the channel is active, holds no descriptor and has no termination pending. The producer holds `desc_valid` and `desc_beats` stable until the handshake. Bus pairs leave on a second valid/ready stream. Once raised, `op_valid` stays high until `op_ready` is seen, and the engine reports completion of the write half with a one-cycle `op_done` pulse.

Top module: `dma_term_ctrl`

## Requirements
- R1: `chan_start` sets `chan_active` only when `cfg_ext_req` is 1 and `cfg_single_addr` is 0. Any other combination leaves the channel idle.
- R2: `xfer_ack` is high from the handshake of a descriptor's final pair until that pair's `op_done`, and at no other time. There is exactly one acknowledge per descriptor. A beat count of zero is treated as one beat.
- R3: At most one pair is outstanding at a time, and `op_valid` is held while `op_ready` is low. `desc_ready` is high only when the channel is active, no descriptor is loaded, no pair is in flight and no termination is pending.
- R4: When the final pair completes without done, the transfer-end flag is set. If `cfg_chain_en` is 1, the next descriptor is requested. Otherwise the chain-end flag is set and `chan_active` clears.
- R5: `cfg_done_mode` codes 01 and 11 make `done_n_in` an input. With codes 00 and 10 the pin has no effect.
- R6: A synchronized falling edge of `done_n_in` under an input code, on an active channel, outside the acknowledge window and with no termination in progress, sets the protocol-error flag. It has no other effect.
- R7: A done edge accepted during the acknowledge window with `cfg_chain_end` = 1 sets the external-done, transfer-end and chain-end flags, clears `chan_active`, and no further descriptor is requested.
- R8: A done edge accepted with `cfg_chain_end` = 0 sets the external-done and transfer-end flags. The chain then continues or ends as selected by `cfg_chain_en`, as in R4.
- R9: `done_n_in` passes through two synchronizer flops, so a low level present before edge E is accepted at edge E+2. The termination outcome is registered exactly three edges after acceptance, and not before the in-flight pair's `op_done`. While it is pending, `op_valid` and `desc_ready` stay low.
- R10: With code 11 and `cfg_chain_end` = 0, completion of the final pair raises `done_n_oe` (data `done_n_out` is constant 0) while the channel is active. Three edges later the outcome of R8 is registered, including the external-done flag, and the enable drops. With `cfg_chain_end` = 1 the block never drives the line.
- R11: The `flags` bits are external-done [0], transfer-end [1], chain-end [2] and protocol-error [3]. They are sticky, and a bit clears only when the same bit of `flag_clr` is 1. A set in the same cycle wins over a clear.
- R12: After reset, `chan_active`, `desc_ready`, `op_valid`, `xfer_ack`, `done_n_oe` and `flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_req | input | 1 | External-request transfer mode |
| cfg_single_addr | input | 1 | Single-address transfer select (must be 0) |
| cfg_chain_end | input | 1 | Done ends the whole chain when 1 |
| cfg_chain_en | input | 1 | Continue to the next descriptor after one ends |
| cfg_done_mode | input | 2 | Done pin role: 00/10 unused, 01 input, 11 bidirectional |
| chan_start | input | 1 | Start strobe for the channel |
| flag_clr | input | 4 | Write-one-to-clear strobes for `flags` |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted |
| desc_beats | input | BEAT_W | Number of read/write pairs in the descriptor |
| op_valid | output | 1 | Request to start one read/write pair |
| op_ready | input | 1 | Bus engine accepts the pair |
| op_done | input | 1 | Write half of the outstanding pair finished |
| xfer_ack | output | 1 | Acknowledge for the final pair of a descriptor |
| done_n_in | input | 1 | Resolved active-low done line |
| done_n_out | output | 1 | Done drive data, constant 0 |
| done_n_oe | output | 1 | Done drive enable (open drain) |
| chan_active | output | 1 | Channel active |
| flags | output | 4 | Sticky status flags |

## Verification
The bench builds the block with a 3-bit beat count, the default three-cycle stop latency and a two-flop synchronizer. The narrow count lets one chain sweep every descriptor length from zero to four, including the zero-as-one case, and compare the expected acknowledge position for each beat. All four done-mode codes are swept against both chain-end and chain-enable settings, and each of the 16 outcomes is computed from the control bits. Done timing is checked cycle by cycle, both for an externally pulled line and for the self-driven line, which is resolved against a modelled pull-up.

// File: rtl/dmat_pkg.sv
package dmat_pkg;

  typedef enum logic [1:0] {
    DN_OFF   = 2'b00,
    DN_IN    = 2'b01,
    DN_RSV   = 2'b10,
    DN_BIDIR = 2'b11
  } dn_mode_e;

  localparam int FLAG_N  = 4;
  localparam int FL_EXT  = 0;
  localparam int FL_XFER = 1;
  localparam int FL_CHN  = 2;
  localparam int FL_PERR = 3;

endpackage

// File: rtl/dmat_sync.sv
module dmat_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES-1:0] stage_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b1;
          else        stage_q[g] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b1;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= stage_q[STAGES-1];
  end

  assign fall = last_q & ~stage_q[STAGES-1];

endmodule

// File: rtl/dmat_beat.sv
module dmat_beat #(
  parameter int BEAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              hold,
  input  logic              desc_end,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [BEAT_W-1:0] desc_beats,
  output logic              op_valid,
  input  logic              op_ready,
  input  logic              op_done,
  output logic              busy,
  output logic              ack,
  output logic              final_done
);
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  logic              loaded_q;
  logic              inflight_q;
  logic [BEAT_W-1:0] left_q;
  logic              desc_hs;
  logic              op_hs;

  assign desc_ready = active & ~loaded_q & ~inflight_q & ~hold;
  assign op_valid   = active & loaded_q & ~inflight_q & (left_q != '0) & ~hold;
  assign desc_hs    = desc_valid & desc_ready;
  assign op_hs      = op_valid & op_ready;
  assign busy       = inflight_q;
  assign ack        = inflight_q & (left_q == '0);
  assign final_done = ack & op_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q   <= 1'b0;
      inflight_q <= 1'b0;
      left_q     <= '0;
    end else begin
      if (!active || desc_end) begin
        loaded_q <= 1'b0;
      end else if (desc_hs) begin
        loaded_q <= 1'b1;
      end

      if (desc_hs) begin
        left_q <= (desc_beats == '0) ? ONE : desc_beats;
      end else if (op_hs) begin
        left_q <= left_q - ONE;
      end

      if (op_hs) begin
        inflight_q <= 1'b1;
      end else if (op_done && inflight_q) begin
        inflight_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dmat_term.sv
module dmat_term
  import dmat_pkg::*;
#(
  parameter int STOP_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ok,
  input  logic              start,
  input  logic              chain_end,
  input  logic              chain_en,
  input  dn_mode_e          mode,
  input  logic [FLAG_N-1:0] clr,
  input  logic              fall,
  input  logic              ack,
  input  logic              busy,
  input  logic              final_done,
  output logic              active,
  output logic              pending,
  output logic              desc_end,
  output logic              drive_oe,
  output logic [FLAG_N-1:0] flags
);
  localparam int CNT_W = (STOP_LAT > 2) ? $clog2(STOP_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STOP_LAT - 1);

  logic              active_q;
  logic              pend_q;
  logic              self_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FLAG_N-1:0] flags_q;
  logic [FLAG_N-1:0] set_v;

  logic listen, quiet, bidir;
  logic accept_ext, perr, self_go, normal_end, finish, stop_all;

  assign listen     = mode[0];
  assign bidir      = (mode == DN_BIDIR);
  assign quiet      = ~pend_q & ~self_q;
  assign accept_ext = fall & listen & ack & quiet;
  assign perr       = fall & listen & active_q & ~ack & quiet;
  assign self_go    = final_done & quiet & ~accept_ext & bidir & ~chain_end;
  assign normal_end = final_done & quiet & ~accept_ext & ~self_go;
  assign finish     = pend_q & (cnt_q == '0) & ~busy;
  assign stop_all   = chain_end | ~chain_en;

  always_comb begin
    set_v          = '0;
    set_v[FL_EXT]  = finish;
    set_v[FL_XFER] = finish | normal_end;
    set_v[FL_CHN]  = (finish & stop_all) | (normal_end & ~chain_en);
    set_v[FL_PERR] = perr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      self_q   <= 1'b0;
      cnt_q    <= '0;
      flags_q  <= '0;
    end else begin
      flags_q <= (flags_q & ~clr) | set_v;

      if (set_v[FL_CHN]) begin
        active_q <= 1'b0;
      end else if (start && mode_ok) begin
        active_q <= 1'b1;
      end

      if (accept_ext || self_go) begin
        pend_q <= 1'b1;
        cnt_q  <= CNT_LOAD;
      end else if (finish) begin
        pend_q <= 1'b0;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end

      if (self_go) begin
        self_q <= 1'b1;
      end else if (finish) begin
        self_q <= 1'b0;
      end
    end
  end

  assign active   = active_q;
  assign pending  = pend_q;
  assign desc_end = finish | normal_end;
  assign drive_oe = self_q & active_q & bidir;
  assign flags    = flags_q;

endmodule

// File: rtl/dma_term_ctrl.sv
module dma_term_ctrl
  import dmat_pkg::*;
#(
  parameter int BEAT_W      = 8,
  parameter int STOP_LAT    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ext_req,
  input  logic              cfg_single_addr,
  input  logic              cfg_chain_end,
  input  logic              cfg_chain_en,
  input  logic [1:0]        cfg_done_mode,
  input  logic              chan_start,
  input  logic [FLAG_N-1:0] flag_clr,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [BEAT_W-1:0] desc_beats,
  output logic              op_valid,
  input  logic              op_ready,
  input  logic              op_done,
  output logic              xfer_ack,
  input  logic              done_n_in,
  output logic              done_n_out,
  output logic              done_n_oe,
  output logic              chan_active,
  output logic [FLAG_N-1:0] flags
);
  dn_mode_e mode_e;
  logic     mode_ok;
  logic     done_fall;
  logic     term_pend;
  logic     desc_end;
  logic     beat_busy;
  logic     final_done;

  assign mode_e     = dn_mode_e'(cfg_done_mode);
  assign mode_ok    = cfg_ext_req & ~cfg_single_addr;
  assign done_n_out = 1'b0;

  dmat_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (done_n_in),
    .fall  (done_fall)
  );

  dmat_beat #(.BEAT_W(BEAT_W)) u_beat (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (chan_active),
    .hold       (term_pend),
    .desc_end   (desc_end),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .desc_beats (desc_beats),
    .op_valid   (op_valid),
    .op_ready   (op_ready),
    .op_done    (op_done),
    .busy       (beat_busy),
    .ack        (xfer_ack),
    .final_done (final_done)
  );

  dmat_term #(.STOP_LAT(STOP_LAT)) u_term (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_ok    (mode_ok),
    .start      (chan_start),
    .chain_end  (cfg_chain_end),
    .chain_en   (cfg_chain_en),
    .mode       (mode_e),
    .clr        (flag_clr),
    .fall       (done_fall),
    .ack        (xfer_ack),
    .busy       (beat_busy),
    .final_done (final_done),
    .active     (chan_active),
    .pending    (term_pend),
    .desc_end   (desc_end),
    .drive_oe   (done_n_oe),
    .flags      (flags)
  );

endmodule

// File: rtl/dma_term_ctrl_chk.sv
module dma_term_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_ext_req,
  input logic       cfg_single_addr,
  input logic [1:0] cfg_done_mode,
  input logic       op_valid,
  input logic       op_ready,
  input logic       desc_ready,
  input logic       xfer_ack,
  input logic       done_n_oe,
  input logic       chan_active,
  input logic [3:0] flags,
  input logic [3:0] flag_clr,
  input logic       term_pend
);

  p_start_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_active) |-> $past(cfg_ext_req && !cfg_single_addr));

  p_ack_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> !op_valid);

  p_valid_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> op_valid);

  p_fetch_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> (chan_active && !xfer_ack));

  p_idle_marks_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chan_active) |-> flags[2]);

  p_pend_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    term_pend |-> (!op_valid && !desc_ready));

  p_drive_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_n_oe |-> ((cfg_done_mode == 2'b11) && chan_active));

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));

endmodule

bind dma_term_ctrl dma_term_ctrl_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_ext_req     (cfg_ext_req),
  .cfg_single_addr (cfg_single_addr),
  .cfg_done_mode   (cfg_done_mode),
  .op_valid        (op_valid),
  .op_ready        (op_ready),
  .desc_ready      (desc_ready),
  .xfer_ack        (xfer_ack),
  .done_n_oe       (done_n_oe),
  .chan_active     (chan_active),
  .flags           (flags),
  .flag_clr        (flag_clr),
  .term_pend       (term_pend)
);

// File: tb/dma_term_ctrl_bench.sv
module dma_term_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_ext_req = 1'b0, cfg_single_addr = 1'b0, cfg_chain_end = 1'b0, cfg_chain_en = 1'b0;
  logic [1:0] cfg_done_mode = 2'b00;
  logic chan_start = 1'b0;
  logic [3:0] flag_clr = 4'h0;
  logic desc_valid = 1'b0;
  logic [BW-1:0] desc_beats = '0;
  logic op_ready = 1'b0, op_done = 1'b0;
  logic ext_low = 1'b0;
  logic desc_ready, op_valid, xfer_ack, done_n_out, done_n_oe, chan_active;
  logic [3:0] flags;
  wire done_line = (done_n_oe ? done_n_out : 1'b1) & ~ext_low;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_term_ctrl #(.BEAT_W(BW), .STOP_LAT(3), .SYNC_STAGES(2)) u_dma_term_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_ext_req(cfg_ext_req), .cfg_single_addr(cfg_single_addr),
    .cfg_chain_end(cfg_chain_end), .cfg_chain_en(cfg_chain_en), .cfg_done_mode(cfg_done_mode),
    .chan_start(chan_start), .flag_clr(flag_clr), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_beats(desc_beats), .op_valid(op_valid), .op_ready(op_ready), .op_done(op_done),
    .xfer_ack(xfer_ack), .done_n_in(done_line), .done_n_out(done_n_out), .done_n_oe(done_n_oe),
    .chan_active(chan_active), .flags(flags)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_desc();
    for (int k = 0; k < 40 && !desc_ready; k++) tick();
  endtask

  task automatic wait_op();
    for (int k = 0; k < 40 && !op_valid; k++) tick();
  endtask

  task automatic feed_desc(input int b);
    wait_desc();
    desc_valid = 1'b1;
    desc_beats = BW'(b);
    tick();
    desc_valid = 1'b0;
  endtask

  task automatic issue(output logic a);
    wait_op();
    op_ready = 1'b1;
    tick();
    op_ready = 1'b0;
    a = xfer_ack;
  endtask

  task automatic complete();
    op_done = 1'b1;
    tick();
    op_done = 1'b0;
  endtask

  task automatic clear_flags(input logic [3:0] m);
    flag_clr = m;
    tick();
    flag_clr = 4'h0;
  endtask

  task automatic go(input logic ce, input logic cen, input logic [1:0] md);
    cfg_ext_req = 1'b1; cfg_single_addr = 1'b0;
    cfg_chain_end = ce; cfg_chain_en = cen; cfg_done_mode = md;
    chan_start = 1'b1;
    tick();
    chan_start = 1'b0;
  endtask

  task automatic drain();
    logic a;
    cfg_done_mode = 2'b00;
    cfg_chain_en = 1'b0;
    for (int k = 0; k < 12 && chan_active; k++) begin
      if (desc_ready) feed_desc(1);
      else if (op_valid) begin issue(a); complete(); end
      else tick();
    end
    tick(3);
    clear_flags(4'hF);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    logic a;
    int acks, exp_b;
    logic stop;
    tick(3);
    rst_n = 1'b1;
    tick();
    // R12 reset state
    chk("R12 active", chan_active, 0);
    chk("R12 desc_ready", desc_ready, 0);
    chk("R12 op_valid", op_valid, 0);
    chk("R12 ack", xfer_ack, 0);
    chk("R12 flags", flags, 0);
    chk("R12 oe", done_n_oe, 0);
    chk("R12 line pulled high", done_line, 1);

    // R1 mode gating
    for (int m = 0; m < 4; m++) begin
      cfg_ext_req = m[1]; cfg_single_addr = m[0];
      chan_start = 1'b1; tick(); chan_start = 1'b0; tick();
      chk("R1 start gated", chan_active, (m == 2) ? 1 : 0);
      if (chan_active) drain();
    end

    // R2 R3 R4: beat sweep over descriptor lengths in one chain
    go(1'b0, 1'b1, 2'b00);
    for (int b = 0; b <= 4; b++) begin
      exp_b = (b == 0) ? 1 : b;
      if (b == 4) cfg_chain_en = 1'b0;
      feed_desc(b);
      acks = 0;
      for (int i = 0; i < exp_b; i++) begin
        if (b == 2 && i == 0) begin
          wait_op();
          tick(3);
          chk("R3 valid held under back-pressure", op_valid, 1);
        end
        issue(a);
        chk("R2 ack on final beat only", a, (i == exp_b - 1) ? 1 : 0);
        chk("R3 one pair outstanding", op_valid, 0);
        complete();
        acks += a;
      end
      chk("R2 one ack per descriptor", acks, 1);
      chk("R4 transfer-end flag", flags[1], 1);
      chk("R4 no external flag", flags[0], 0);
      chk("R4 chain-end flag", flags[2], (b == 4) ? 1 : 0);
      chk("R4 active after descriptor", chan_active, (b < 4) ? 1 : 0);
      chk("R3 next fetch requested", desc_ready, (b < 4) ? 1 : 0);
      clear_flags(4'b0010);
      chk("R11 w1c clears bit", flags[1], 0);
    end
    clear_flags(4'hF);

    // R5 R7 R8 R9: done sweep over modes and chain bits
    for (int md = 0; md < 4; md++) begin
      for (int ce = 0; ce < 2; ce++) begin
        for (int cen = 0; cen < 2; cen++) begin
          go(ce[0], cen[0], md[1:0]);
          feed_desc(2);
          issue(a); complete();
          issue(a);
          chk("R2 ack in final pair", a, 1);
          ext_low = 1'b1;
          tick(3);
          ext_low = 1'b0;
          chk("R9 ack held until op_done", xfer_ack, 1);
          op_done = 1'b1; tick(); op_done = 1'b0;
          chk("R10 no self drive after external done", done_n_oe, 0);
          if (md[0]) begin
            stop = ce[0] | ~cen[0];
            chk("R9 outcome not before latency", flags, 0);
            chk("R9 no issue while pending", op_valid | desc_ready, 0);
            tick();
            chk("R9 outcome still pending", flags[1], 0);
            tick();
            if (ce == 1) chk("R7 chain end flags", flags, {1'b0, 1'b1, 1'b1, 1'b1});
            else chk("R8 descriptor end flags", flags, {1'b0, stop, 1'b1, 1'b1});
            chk("R7 R8 active after done", chan_active, stop ? 0 : 1);
            chk("R7 R8 next fetch", desc_ready, stop ? 0 : 1);
            tick();
            chk("R11 flags sticky", flags[0], 1);
          end else begin
            chk("R5 pin ignored", flags, {1'b0, ~cen[0], 1'b1, 1'b0});
            chk("R5 active after normal end", chan_active, cen);
          end
          drain();
        end
      end
    end

    // R10 self-driven done
    for (int cen = 0; cen < 2; cen++) begin
      go(1'b0, cen[0], 2'b11);
      feed_desc(1);
      issue(a);
      op_done = 1'b1; tick(); op_done = 1'b0;
      chk("R10 oe raised", done_n_oe, 1);
      chk("R10 line low", done_line, 0);
      chk("R10 no outcome yet", flags, 0);
      tick(2);
      chk("R10 still pending", flags[1], 0);
      chk("R10 oe held", done_n_oe, 1);
      tick();
      chk("R10 outcome flags", flags, {1'b0, ~cen[0], 1'b1, 1'b1});
      chk("R10 oe released", done_n_oe, 0);
      chk("R10 line high again", done_line, 1);
      drain();
    end
    go(1'b1, 1'b0, 2'b11);
    feed_desc(1);
    issue(a);
    complete();
    chk("R10 chain-end set keeps pin idle", done_n_oe, 0);
    chk("R10 normal flags", flags, 4'b0110);
    drain();

    // R6 protocol error, then R5 ignored pin outside ack
    go(1'b0, 1'b1, 2'b01);
    feed_desc(2);
    ext_low = 1'b1; tick(2); ext_low = 1'b0; tick();
    chk("R6 error flag", flags, 4'b1000);
    chk("R6 channel unaffected", chan_active, 1);
    chk("R6 issue unaffected", op_valid, 1);
    clear_flags(4'b1000);
    chk("R11 error cleared", flags, 0);
    cfg_done_mode = 2'b00;
    tick(3);
    ext_low = 1'b1; tick(2); ext_low = 1'b0; tick(2);
    chk("R5 code 00 ignores pin", flags, 0);
    chk("R5 issue unaffected", op_valid, 1);
    drain();

    summary();
    $finish;
  end

endmodule